// File: doc/BRIEF.md
# Dual-Bank Flash Command Sequencer

This block is the command front end of a behavioural, word-wide flash model split into two banks. It watches single-cycle write strobes on a shared address/data bus and decodes protected unlock sequences. A short sequence arms a word program, and the next strobe supplies the target word and the data. A longer six-strobe sequence starts a sector, block or whole-device erase. The same unlock prefix enters or leaves a product-identification mode. In that mode, reads return a maker code and a code for each bank instead of array data.

Each bank has its own storage, written in a way that lets block RAM be inferred. Each bank also has its own busy flag, driven by a fixed-length timer. While one bank is busy the other can still be read. Any wrong strobe in a sequence drops the decoder back to its idle state. While either bank is busy, every write strobe is ignored.

The top address bit selects the bank. The remaining bits form the in-bank offset, which is compared against the unlock addresses. Array reads take one cycle: `rd_en` is sampled on an edge, and `rdata`/`rvalid` are valid after that edge.

Top module: `dbank_flash_seq`

## Requirements
- R1: The strobes AA@0x5555, 55@0x2AAA, A0@0x5555 arm a program; the next strobe writes its data into the word at its address, and the stored word becomes old AND new.
- R2: The strobes AA@0x5555, 55@0x2AAA, 80@0x5555, AA@0x5555, 55@0x2AAA, then a sixth strobe erase to all ones. A sixth strobe of 30 clears the aligned 2^SEC_AW-word sector holding its address. A sixth strobe of 50 clears the aligned 2^BLK_AW-word block. A sixth strobe of 10 at 0x5555 clears both banks entirely.
- R3: Only data bits 7:0 are compared on command strobes; bits 15:8 may hold any value.
- R4: The decoder advances only on write strobes; cycles without a strobe, including reads of either bank, leave a partial sequence intact.
- R5: A strobe with a wrong address or data byte returns the decoder to idle, so the strobes that follow do not complete the abandoned sequence.
- R6: While either bank is busy, all write strobes are ignored, including unlock, command and data strobes.
- R7: A read of the idle bank returns its stored word while the other bank is busy; a read of a busy bank returns 0x0000. `rdata`/`rvalid` follow `rd_en` by one cycle.
- R8: After AA, 55, then 90@0x5555, reads return the maker code when address bit 0 is 0, and the code of the bank chosen by address bit 15 when bit 0 is 1; program and erase sequences are ignored in this mode.
- R9: AA, 55, then F0@0x5555 leaves identification mode and restores array reads; in normal mode it changes nothing.
- R10: The bank addressed by the committing strobe (both banks for whole-device erase) shows busy from the edge that takes that strobe, for exactly BUSY_CYC cycles; `rdy` is low while any bank is busy.
- R11: Reset leaves `rdy` high, both busy flags low, `rvalid` low and the decoder idle, discarding a partial sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | Read request |
| addr | input | ADDR_W | Bank bit on top, in-bank offset below |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, one cycle after `rd_en` |
| rvalid | output | 1 | `rdata` is valid |
| rdy | output | 1 | High when no bank is busy |
| bank_busy | output | 2 | Busy flag per bank |

## Verification
The assertions assume that `wr_en` is a one-cycle pulse, and that BUSY_CYC exceeds the number of words in a bank, so that an erase walk ends before the timer does. They also assume that `rd_en` and `wr_en` are never high in the same cycle. The stimulus drives every strobe for exactly one cycle between falling edges, and it never overlaps reads and writes. The bench overrides BUSY_CYC to 40 against 32-word banks, which keeps it above the bank size.

// File: rtl/dbank_flash_pkg.sv
package dbank_flash_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SEC  = 2'd1,
    OP_BLK  = 2'd2,
    OP_CHIP = 2'd3
  } flash_op_e;
endpackage

// File: rtl/dbank_cmd_fsm.sv
module dbank_cmd_fsm
  import dbank_flash_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DW = 16,
  parameter int MEM_AW = 8,
  parameter logic [ADDR_W-2:0] UA1 = 'h5555,
  parameter logic [ADDR_W-2:0] UA2 = 'h2AAA,
  parameter logic [7:0] UD1 = 8'hAA,
  parameter logic [7:0] UD2 = 8'h55,
  parameter logic [7:0] CMD_PROG = 8'hA0,
  parameter logic [7:0] CMD_ERASE = 8'h80,
  parameter logic [7:0] CMD_CHIP = 8'h10,
  parameter logic [7:0] CMD_SEC = 8'h30,
  parameter logic [7:0] CMD_BLK = 8'h50,
  parameter logic [7:0] CMD_IDENT = 8'h90,
  parameter logic [7:0] CMD_EXIT = 8'hF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [1:0]        busy_i,
  output logic [1:0]        start_o,
  output flash_op_e         op_o,
  output logic [MEM_AW-1:0] waddr_o,
  output logic [DW-1:0]     wdata_o,
  output logic              id_mode_o
);
  typedef enum logic [2:0] {
    S_IDLE, S_U1, S_U2, S_PROG, S_E1, S_E2, S_E3
  } seq_e;

  seq_e st_q, st_d;
  logic id_q, id_d;
  logic lock, hit1, hit2, at1, bank;
  logic [ADDR_W-2:0] off;
  logic [7:0] lo;

  assign off  = addr_i[ADDR_W-2:0];
  assign bank = addr_i[ADDR_W-1];
  assign lo   = wdata_i[7:0];
  assign at1  = (off == UA1);
  assign hit1 = at1 && (lo == UD1);
  assign hit2 = (off == UA2) && (lo == UD2);
  assign lock = |busy_i;

  always_comb begin
    st_d    = st_q;
    id_d    = id_q;
    start_o = '0;
    op_o    = OP_PROG;
    if (wr_en_i && !lock) begin
      st_d = S_IDLE;
      case (st_q)
        S_IDLE: if (hit1) st_d = S_U1;
        S_U1:   if (hit2) st_d = S_U2;
        S_U2: begin
          if (at1) begin
            if (lo == CMD_EXIT) id_d = 1'b0;
            else if (!id_q) begin
              if (lo == CMD_PROG) st_d = S_PROG;
              else if (lo == CMD_ERASE) st_d = S_E1;
              else if (lo == CMD_IDENT) id_d = 1'b1;
            end
          end
        end
        S_PROG: begin
          start_o[bank] = 1'b1;
          op_o = OP_PROG;
        end
        S_E1: if (hit1) st_d = S_E2;
        S_E2: if (hit2) st_d = S_E3;
        S_E3: begin
          if (lo == CMD_SEC) begin
            start_o[bank] = 1'b1;
            op_o = OP_SEC;
          end else if (lo == CMD_BLK) begin
            start_o[bank] = 1'b1;
            op_o = OP_BLK;
          end else if (lo == CMD_CHIP && at1) begin
            start_o = 2'b11;
            op_o = OP_CHIP;
          end
        end
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= S_IDLE;
      id_q <= 1'b0;
    end else begin
      st_q <= st_d;
      id_q <= id_d;
    end
  end

  assign waddr_o   = addr_i[MEM_AW-1:0];
  assign wdata_o   = wdata_i;
  assign id_mode_o = id_q;

  // R6: decoder state frozen while a bank is busy
  assert_lockout_R6: assert property (@(posedge clk) disable iff (rst)
    (|busy_i) |=> ($stable(st_q) && $stable(id_q)));
  // R6: no operation launched on a busy device
  assert_no_start_busy_R6: assert property (@(posedge clk) disable iff (rst)
    (|start_o) |-> !(|busy_i));
  // R8: identification mode launches nothing
  assert_id_no_start_R8: assert property (@(posedge clk) disable iff (rst)
    id_q |-> (start_o == 2'b00));
  // R8: identification mode never entered while busy
  assert_id_entry_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(id_q) |-> $past(busy_i == 2'b00));
endmodule

// File: rtl/dbank_array.sv
module dbank_array
  import dbank_flash_pkg::*;
#(
  parameter int DW = 16,
  parameter int MEM_AW = 8,
  parameter int SEC_AW = 2,
  parameter int BLK_AW = 4,
  parameter int BUSY_CYC = 300
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  flash_op_e         op_i,
  input  logic [MEM_AW-1:0] waddr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [MEM_AW-1:0] raddr_i,
  output logic              busy_o,
  output logic [DW-1:0]     rdata_o
);
  localparam int DEPTH = 1 << MEM_AW;
  localparam int CNT_W = $clog2(BUSY_CYC + 1);
  localparam logic [MEM_AW-1:0] SEC_MASK = {MEM_AW{1'b1}} << SEC_AW;
  localparam logic [MEM_AW-1:0] BLK_MASK = {MEM_AW{1'b1}} << BLK_AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q, data_q, p_wd;
  logic [MEM_AW-1:0] base_q, base_d, p_addr;
  logic [CNT_W-1:0] cnt_q, len_q, len_d;
  logic busy_q, p_we;
  flash_op_e op_q;

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_comb begin
    case (op_i)
      OP_SEC: begin
        len_d  = CNT_W'(1 << SEC_AW);
        base_d = waddr_i & SEC_MASK;
      end
      OP_BLK: begin
        len_d  = CNT_W'(1 << BLK_AW);
        base_d = waddr_i & BLK_MASK;
      end
      OP_CHIP: begin
        len_d  = CNT_W'(DEPTH);
        base_d = '0;
      end
      default: begin
        len_d  = CNT_W'(1);
        base_d = waddr_i;
      end
    endcase
  end

  // Single memory port: internal walk while busy, host read otherwise
  always_comb begin
    p_addr = raddr_i;
    p_we   = 1'b0;
    p_wd   = '1;
    if (busy_q) begin
      if (op_q == OP_PROG) begin
        p_addr = base_q;
        p_we   = (cnt_q == CNT_W'(1));
        p_wd   = rd_q & data_q;
      end else begin
        p_addr = base_q | cnt_q[MEM_AW-1:0];
        p_we   = (cnt_q < len_q);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (p_we) mem[p_addr] <= p_wd;
    rd_q <= mem[p_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_PROG;
      base_q <= '0;
      len_q  <= '0;
      data_q <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      op_q   <= op_i;
      base_q <= base_d;
      len_q  <= len_d;
      data_q <= wdata_i;
    end else if (busy_q) begin
      if (cnt_q == CNT_W'(BUSY_CYC - 1)) busy_q <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o  = busy_q;
  assign rdata_o = rd_q;

  // Independent age counter for the busy window
  logic [CNT_W-1:0] age_q;
  always_ff @(posedge clk) begin
    if (rst || !busy_q) age_q <= '0;
    else age_q <= age_q + 1'b1;
  end

  // R10: busy lasts exactly BUSY_CYC cycles
  assert_busy_len_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> (age_q == CNT_W'(BUSY_CYC)));
  // R10: the window never overruns
  assert_busy_cap_R10: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (age_q < CNT_W'(BUSY_CYC)));
endmodule

// File: rtl/dbank_flash_seq.sv
module dbank_flash_seq
  import dbank_flash_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DW = 16,
  parameter int MEM_AW = 8,
  parameter int SEC_AW = 2,
  parameter int BLK_AW = 4,
  parameter int BUSY_CYC = 300,
  parameter logic [DW-1:0] MFR_ID = 'h00A5,
  parameter logic [DW-1:0] DEV_ID0 = 'h1A01,
  parameter logic [DW-1:0] DEV_ID1 = 'h1A02
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              rvalid,
  output logic              rdy,
  output logic [1:0]        bank_busy
);
  localparam int NBANK = 2;

  logic [NBANK-1:0] start, busy;
  logic [DW-1:0] bank_rd [NBANK];
  logic [MEM_AW-1:0] waddr;
  logic [DW-1:0] cmd_data;
  logic id_mode;
  flash_op_e op;

  dbank_cmd_fsm #(
    .ADDR_W(ADDR_W), .DW(DW), .MEM_AW(MEM_AW)
  ) u_fsm (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .busy_i(busy), .start_o(start), .op_o(op), .waddr_o(waddr),
    .wdata_o(cmd_data), .id_mode_o(id_mode)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    dbank_array #(
      .DW(DW), .MEM_AW(MEM_AW), .SEC_AW(SEC_AW), .BLK_AW(BLK_AW),
      .BUSY_CYC(BUSY_CYC)
    ) u_array (
      .clk(clk), .rst(rst), .start_i(start[b]), .op_i(op), .waddr_i(waddr),
      .wdata_i(cmd_data), .raddr_i(addr[MEM_AW-1:0]),
      .busy_o(busy[b]), .rdata_o(bank_rd[b])
    );
  end

  // Read path: request attributes registered alongside the array read
  logic rv_q, rbank_q, rid_q, rsel_q, rbusy_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      rv_q <= 1'b0; rbank_q <= 1'b0; rid_q <= 1'b0;
      rsel_q <= 1'b0; rbusy_q <= 1'b0;
    end else begin
      rv_q    <= rd_en;
      rbank_q <= addr[ADDR_W-1];
      rid_q   <= id_mode;
      rsel_q  <= addr[0];
      rbusy_q <= busy[addr[ADDR_W-1]];
    end
  end

  always_comb begin
    if (!rv_q) rdata = '0;
    else if (rid_q) rdata = rsel_q ? (rbank_q ? DEV_ID1 : DEV_ID0) : MFR_ID;
    else if (rbusy_q) rdata = '0;
    else rdata = bank_rd[rbank_q];
  end

  assign rvalid    = rv_q;
  assign bank_busy = busy;
  assign rdy       = !(|busy);

  // R10: a busy flag only rises on the edge that took a write strobe
  assert_busy_cause_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(|busy) |-> $past(wr_en));
  // R7: read valid tracks the request one cycle later
  assert_rvalid_R7: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rvalid);
endmodule

// File: tb/dbank_flash_seq_bench.sv
module dbank_flash_seq_bench;
  localparam int BUSY = 40;
  localparam logic [15:0] MFR = 16'h00A5, D0 = 16'h1A01, D1 = 16'h1A02;
  localparam logic [1:0] OW = 2'd0, ORD = 2'd1, OWT = 2'd2, OBZ = 2'd3;
  localparam int NV = 62;
  // {op, addr, data-or-expected, requirement number}
  localparam logic [41:0] VEC [NV] = '{
    {OW,16'h5555,16'h00AA,8'd1}, {OW,16'h2AAA,16'h0055,8'd1},   // R1 program
    {OW,16'h5555,16'h00A0,8'd1}, {OW,16'h0003,16'h1234,8'd1},
    {OBZ,16'h0000,16'h0001,8'd10},                               // R10 bank0 busy
    {ORD,16'h8005,16'hFFFF,8'd7}, {ORD,16'h0003,16'h0000,8'd7},  // R7
    {OWT,16'h0,16'h0,8'd10}, {ORD,16'h0003,16'h1234,8'd1},
    {OW,16'h5555,16'h12AA,8'd3}, {OW,16'h2AAA,16'h3455,8'd3},   // R3 high byte junk
    {OW,16'h5555,16'h77A0,8'd3}, {OW,16'h0003,16'hFF0F,8'd3},
    {OWT,16'h0,16'h0,8'd3}, {ORD,16'h0003,16'h1204,8'd1},        // R1 AND
    {OW,16'h5555,16'h00AA,8'd5}, {OW,16'h2AAA,16'h0056,8'd5},   // R5 abort
    {OW,16'h5555,16'h00A0,8'd5}, {OW,16'h0004,16'h0000,8'd5},
    {OBZ,16'h0,16'h0000,8'd5}, {ORD,16'h0004,16'hFFFF,8'd5},
    {OW,16'h5555,16'h00AA,8'd4}, {ORD,16'h8002,16'hFFFF,8'd4},  // R4 pauses
    {OW,16'h2AAA,16'h0055,8'd4}, {ORD,16'h0003,16'h1204,8'd4},
    {OW,16'h5555,16'h00A0,8'd4}, {OW,16'h800C,16'h0000,8'd4},
    {OBZ,16'h0,16'h0002,8'd10}, {OWT,16'h0,16'h0,8'd4},
    {ORD,16'h800C,16'h0000,8'd4},
    {OW,16'h5555,16'h00AA,8'd1}, {OW,16'h2AAA,16'h0055,8'd1},
    {OW,16'h5555,16'h00A0,8'd1}, {OW,16'h8009,16'h0000,8'd1},
    {OWT,16'h0,16'h0,8'd1},
    {OW,16'h5555,16'h00AA,8'd2}, {OW,16'h2AAA,16'h0055,8'd2},   // R2 sector
    {OW,16'h5555,16'h0080,8'd2}, {OW,16'h5555,16'h00AA,8'd2},
    {OW,16'h2AAA,16'h0055,8'd2}, {OW,16'h800A,16'h0030,8'd2},
    {OBZ,16'h0,16'h0002,8'd2}, {OWT,16'h0,16'h0,8'd2},
    {ORD,16'h8009,16'hFFFF,8'd2}, {ORD,16'h800C,16'h0000,8'd2},
    {OW,16'h5555,16'h00AA,8'd8}, {OW,16'h2AAA,16'h0055,8'd8},   // R8 ID entry
    {OW,16'h5555,16'h0090,8'd8},
    {ORD,16'h0000,MFR,8'd8}, {ORD,16'h0001,D0,8'd8},
    {ORD,16'h8001,D1,8'd8}, {ORD,16'h8007,D1,8'd8},
    {OW,16'h5555,16'h00AA,8'd8}, {OW,16'h2AAA,16'h0055,8'd8},
    {OW,16'h5555,16'h00A0,8'd8}, {OW,16'h0004,16'h0000,8'd8},
    {OBZ,16'h0,16'h0000,8'd8},
    {OW,16'h5555,16'h00AA,8'd9}, {OW,16'h2AAA,16'h0055,8'd9},   // R9 exit
    {OW,16'h5555,16'h00F0,8'd9},
    {ORD,16'h0004,16'hFFFF,8'd8}, {ORD,16'h0000,16'hFFFF,8'd9}
  };

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] addr = '0, wdata = '0, rdata;
  logic rvalid, rdy;
  logic [1:0] bank_busy;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dbank_flash_seq #(
    .ADDR_W(16), .DW(16), .MEM_AW(5), .SEC_AW(2), .BLK_AW(3),
    .BUSY_CYC(BUSY), .MFR_ID(MFR), .DEV_ID0(D0), .DEV_ID1(D1)
  ) u_dbank_flash_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .rdy(rdy),
    .bank_busy(bank_busy)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] q);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    q = rvalid ? rdata : 16'hDEAD;
  endtask

  task automatic wait_rdy();
    while (!rdy) @(negedge clk);
  endtask

  task automatic chk_busy(input string req, input logic [1:0] exp);
    check(req, {14'd0, bank_busy}, {14'd0, exp});
    check(req, {15'd0, rdy}, {15'd0, exp == 2'b00});
  endtask

  task automatic unlock();
    wr(16'h5555, 16'h00AA);
    wr(16'h2AAA, 16'h0055);
  endtask

  task automatic prog(input logic [15:0] a, input logic [15:0] d);
    unlock(); wr(16'h5555, 16'h00A0); wr(a, d);
  endtask

  task automatic erase(input logic [15:0] a, input logic [7:0] c);
    unlock(); wr(16'h5555, 16'h0080); unlock(); wr(a, {8'h00, c});
  endtask

  initial begin
    logic [15:0] q;
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk_busy("R11", 2'b00);
    check("R11", {15'd0, rvalid}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic [15:0] va, vd;
      string tag;
      op = VEC[i][41:40]; va = VEC[i][39:24]; vd = VEC[i][23:8];
      tag = $sformatf("R%0d", VEC[i][7:0]);
      case (op)
        OW:  wr(va, vd);
        ORD: begin rd(va, q); check(tag, q, vd); end
        OWT: wait_rdy();
        default: chk_busy(tag, vd[1:0]);
      endcase
    end

    // R10: exact busy length
    prog(16'h0001, 16'h00FF);
    n = 0;
    while (bank_busy != 2'b00) begin n++; @(negedge clk); end
    check("R10", 16'(n), 16'(BUSY));

    // R2: block erase of offsets 0..7 in bank 0
    erase(16'h0005, 8'h50);
    chk_busy("R2", 2'b01);
    wait_rdy();
    rd(16'h0001, q); check("R2", q, 16'hFFFF);
    rd(16'h0003, q); check("R2", q, 16'hFFFF);

    // R6: program to bank 1 issued while bank 0 busy is ignored
    prog(16'h0010, 16'h00F0);
    prog(16'h800E, 16'h0000);
    chk_busy("R6", 2'b01);
    wait_rdy();
    rd(16'h800E, q); check("R6", q, 16'hFFFF);
    rd(16'h0010, q); check("R1", q, 16'h00F0);

    // R2: whole-device erase busies both banks
    erase(16'h5555, 8'h10);
    chk_busy("R2", 2'b11);
    wait_rdy();
    rd(16'h800C, q); check("R2", q, 16'hFFFF);
    rd(16'h0010, q); check("R2", q, 16'hFFFF);

    // R11: reset mid-sequence discards the partial unlock
    unlock();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    wr(16'h5555, 16'h00A0);
    wr(16'h0004, 16'h0000);
    chk_busy("R11", 2'b00);
    rd(16'h0004, q); check("R11", q, 16'hFFFF);

    // R9: exit in normal mode is harmless
    unlock(); wr(16'h5555, 16'h00F0);
    rd(16'h0004, q); check("R9", q, 16'hFFFF);
    prog(16'h0004, 16'h00C3);
    wait_rdy();
    rd(16'h0004, q); check("R9", q, 16'h00C3);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule